// File: doc/BRIEF.md
# Transmit Credit and Error Monitor

This block sits beside a group of transmit DMA channels and keeps score of the flow-control credit each channel holds toward its downstream transmit FIFO. Every channel has a small configuration word holding a run mode and a request-enable bit. While a channel is not halted, its credit counter follows grant and consume strobes. The counter saturates at both ends.

The block also watches for protocol faults and latches each one into a sticky error word that software clears by writing ones. There are four kinds of fault. A FIFO-full indication while the channel still holds credit shows that the credit accounting has drifted. An activate command while the channel's request buffer is still occupied is a second fault. The remaining two are a dword-count mismatch and an internal address fault. A shared status word gives, for each channel, whether its buffers are empty and whether it has no request pending.

Register map (word addresses on `reg_addr`, with NUM_CH = 8): addresses 0..7 hold the channel configuration; addresses 8..15 return the channel credit counters, read-only; address 16 holds the error word; address 17 holds the status word, read-only. Other addresses read as zero.

Top module: `tx_credit_monitor`

## Requirements
- R1: After reset, every configuration word, credit counter and error flag reads zero. With no request buffer busy, the status word reads 0xFFFF0000.
- R2: A configuration write keeps only bits 31:30 (mode: 00 halt, 01 stop at end of frame, 10 run) and bit 3 (request enable). All other bits read back as zero.
- R3: In a cycle with a grant and no consume, a non-halted channel's credit rises by one. The credit stops rising at CRED_MAX (31 by default).
- R4: In a cycle with a consume and no grant, the credit falls by one and stops at zero. A cycle with both a grant and a consume leaves the credit unchanged.
- R5: While a channel's mode is 00, its credit is forced to zero and grants are ignored. Mode 01 counts credit the same way as mode 10.
- R6: Error bit c (bits 7:0) sets when fifo_full[c] is high while channel c's credit is nonzero. It does not set when the credit is zero.
- R7: Error bit 9+c (bits 16:9) sets when act_cmd[c] is high while req_buf_busy[c] is high. It does not set when the buffer is free.
- R8: Error bit 31 sets on addr_err, and error bit 30 sets on dwcnt_err.
- R9: Writing to the error word clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R10: A flag that is set and cleared in the same cycle ends that cycle set.
- R11: Status bit 24+c is the inverse of req_buf_busy[c]. Status bit 16+c is 0 only when channel c is in mode 10 with request enable set and nonzero credit.
- R12: Reading address NUM_CH+c returns channel c's credit in the low bits, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| credit_grant | input | NUM_CH | Per-channel credit return strobe |
| credit_use | input | NUM_CH | Per-channel credit consume strobe |
| fifo_full | input | NUM_CH | Per-channel downstream FIFO full indication |
| act_cmd | input | NUM_CH | Per-channel activate-DMA command strobe |
| req_buf_busy | input | NUM_CH | Per-channel request buffer occupied |
| addr_err | input | 1 | Internal memory address fault strobe |
| dwcnt_err | input | 1 | Host dword-count mismatch strobe |

## Verification
The hardest case to reach is the overlap of an incoming fault with a write-one clear of the same flag, because both must land on the same clock edge. The bench drives the error strobe and the clear write together in one cycle and then reads the flag. Saturation at the top of the credit range also needs some setup. The bench puts a channel into run mode and holds the grant strobe for more cycles than the counter can count. It then checks that a later full indication raises the credit error only because credit is still held.

// File: rtl/tx_mon_pkg.sv
package tx_mon_pkg;

    // Channel run mode, held in configuration bits 31:30
    typedef enum logic [1:0] {
        MODE_HALT  = 2'b00,
        MODE_DRAIN = 2'b01,
        MODE_RUN   = 2'b10,
        MODE_RSVD  = 2'b11
    } chan_mode_e;

    typedef struct packed {
        chan_mode_e mode;
        logic       req_en;
    } chan_cfg_t;

    localparam int DATA_W         = 32;
    localparam int CFG_MODE_LSB   = 30;
    localparam int CFG_REQ_BIT    = 3;
    localparam int ERR_CRED_LSB   = 0;
    localparam int ERR_ACT_LSB    = 9;
    localparam int ERR_DWC_BIT    = 30;
    localparam int ERR_ADDR_BIT   = 31;
    localparam int STS_NOPEND_LSB = 16;
    localparam int STS_EMPTY_LSB  = 24;

endpackage

// File: rtl/tx_credit_ctr.sv
module tx_credit_ctr #(
    parameter int CRED_MAX = 31,
    parameter int CRED_W   = $clog2(CRED_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_on,
    input  logic              grant,
    input  logic              consume,
    output logic [CRED_W-1:0] credit
);

    localparam logic [CRED_W-1:0] TOP = CRED_W'(CRED_MAX);

    typedef struct packed {
        logic [CRED_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!chan_on) begin
            st_d.cnt = '0;
        end else if (grant && !consume && st_q.cnt != TOP) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (consume && !grant && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign credit = st_q.cnt;

    p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        credit <= TOP);
    p_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chan_on && grant && !consume && credit != TOP |=> credit == $past(credit) + 1'b1);
    p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_on && consume && !grant && credit == '0 |=> credit == '0);
    p_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_on && consume && grant |=> $stable(credit));
    p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_on |=> credit == '0);

endmodule

// File: rtl/tx_err_flags.sv
module tx_err_flags #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);

    typedef struct packed {
        logic [W-1:0] err;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = (st_q.err & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.err;

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags & $past(set_vec)) == $past(set_vec));
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags & $past(clr_vec & ~set_vec)) == '0);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags & ~$past(clr_vec)) == ($past(flags | set_vec) & ~$past(clr_vec)));

endmodule

// File: rtl/tx_credit_monitor.sv
module tx_credit_monitor
    import tx_mon_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int CRED_MAX = 31,
    parameter int ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] credit_grant,
    input  logic [NUM_CH-1:0] credit_use,
    input  logic [NUM_CH-1:0] fifo_full,
    input  logic [NUM_CH-1:0] act_cmd,
    input  logic [NUM_CH-1:0] req_buf_busy,
    input  logic              addr_err,
    input  logic              dwcnt_err
);

    localparam int CRED_W   = $clog2(CRED_MAX + 1);
    localparam int CRED_REG = NUM_CH;
    localparam int ERR_REG  = 2 * NUM_CH;
    localparam int STS_REG  = 2 * NUM_CH + 1;

    localparam logic [DATA_W-1:0] ERR_MASK =
        (DATA_W'((1 << NUM_CH) - 1) << ERR_CRED_LSB) |
        (DATA_W'((1 << NUM_CH) - 1) << ERR_ACT_LSB) |
        (DATA_W'(1) << ERR_DWC_BIT) | (DATA_W'(1) << ERR_ADDR_BIT);

    initial begin
        a_layout: assert (NUM_CH <= 8 && (1 << ADDR_W) >= STS_REG + 1);
    end

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] cfg;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic [NUM_CH-1:0][CRED_W-1:0] credit;
    logic [NUM_CH-1:0]             chan_on;
    logic [DATA_W-1:0]             err_set, err_clr, err_word, sts_word;

    // Configuration registers
    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_wr && reg_addr == ADDR_W'(c)) begin
                st_d.cfg[c].mode   = chan_mode_e'(reg_wdata[CFG_MODE_LSB +: 2]);
                st_d.cfg[c].req_en = reg_wdata[CFG_REQ_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Per-channel credit counters
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign chan_on[g] = (st_q.cfg[g].mode != MODE_HALT);

        tx_credit_ctr #(
            .CRED_MAX (CRED_MAX),
            .CRED_W   (CRED_W)
        ) i_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .chan_on (chan_on[g]),
            .grant   (credit_grant[g]),
            .consume (credit_use[g]),
            .credit  (credit[g])
        );

        p_cred_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_full[g] && credit[g] != '0 |=> err_word[ERR_CRED_LSB + g]);
        p_act_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
            act_cmd[g] && req_buf_busy[g] |=> err_word[ERR_ACT_LSB + g]);
    end

    // Error set and clear vectors
    always_comb begin
        err_set = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            err_set[ERR_CRED_LSB + c] = fifo_full[c] && (credit[c] != '0);
            err_set[ERR_ACT_LSB + c]  = act_cmd[c] && req_buf_busy[c];
        end
        err_set[ERR_DWC_BIT]  = dwcnt_err;
        err_set[ERR_ADDR_BIT] = addr_err;
        err_clr = (reg_wr && reg_addr == ADDR_W'(ERR_REG)) ? (reg_wdata & ERR_MASK) : '0;
    end

    tx_err_flags #(.W(DATA_W)) i_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (err_set),
        .clr_vec (err_clr),
        .flags   (err_word)
    );

    // Shared status word
    always_comb begin
        sts_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            sts_word[STS_EMPTY_LSB + c]  = !req_buf_busy[c];
            sts_word[STS_NOPEND_LSB + c] = !(st_q.cfg[c].mode == MODE_RUN &&
                                             st_q.cfg[c].req_en && credit[c] != '0);
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADDR_W'(c)) begin
                reg_rdata[CFG_MODE_LSB +: 2] = st_q.cfg[c].mode;
                reg_rdata[CFG_REQ_BIT]       = st_q.cfg[c].req_en;
            end
            if (reg_addr == ADDR_W'(CRED_REG + c)) begin
                reg_rdata = DATA_W'(credit[c]);
            end
        end
        if (reg_addr == ADDR_W'(ERR_REG)) reg_rdata = err_word;
        if (reg_addr == ADDR_W'(STS_REG)) reg_rdata = sts_word;
    end

    p_dwc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dwcnt_err |=> err_word[ERR_DWC_BIT]);
    p_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> err_word[ERR_ADDR_BIT]);
    p_cfg_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr < ADDR_W'(NUM_CH) |-> (reg_rdata & ~32'hC000_0008) == '0);

endmodule

// File: tb/test_tx_credit_monitor.sv
module test_tx_credit_monitor;

    localparam int NCH = 8;
    localparam int AW  = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] credit_grant = '0, credit_use = '0, fifo_full = '0;
    logic [NCH-1:0] act_cmd = '0, req_buf_busy = '0;
    logic           addr_err = 1'b0, dwcnt_err = 1'b0;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tx_credit_monitor #(.NUM_CH(NCH), .CRED_MAX(31), .ADDR_W(AW)) i_tx_credit_monitor (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .credit_grant, .credit_use, .fifo_full, .act_cmd, .req_buf_busy,
        .addr_err, .dwcnt_err
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    // Monitor: pops each expected read and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_run++;
                if (reg_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %08h expected %08h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_wr   = 1'b0;
        reg_addr = AW'(a);
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic strobe(input logic [NCH-1:0] g, u, ff, ac, input logic ae, de);
        @(negedge clk);
        credit_grant = g; credit_use = u; fifo_full = ff; act_cmd = ac;
        addr_err = ae; dwcnt_err = de;
        @(negedge clk);
        credit_grant = '0; credit_use = '0; fifo_full = '0; act_cmd = '0;
        addr_err = 1'b0; dwcnt_err = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(16, 32'h0, "R1 error word");
        rd(17, 32'hFFFF_0000, "R1 status word");
        rd(0, 32'h0, "R1 config");
        rd(8, 32'h0, "R1 credit");
        // R2 write masking
        wr(0, 32'hFFFF_FFFF);
        rd(0, 32'hC000_0008, "R2 masked config");
        wr(0, 32'h8000_0008);
        rd(0, 32'h8000_0008, "R2 run config");
        // R3 count up, R12 readback, R11 pending
        repeat (3) strobe(8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
        rd(8, 32'd3, "R12 R3 credit after 3 grants");
        rd(17, 32'hFFFE_0000, "R11 ch0 pending");
        // R4 grant+consume together, then floor
        strobe(8'h01, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0);
        rd(8, 32'd3, "R4 both strobes");
        repeat (5) strobe(8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0);
        rd(8, 32'd0, "R4 floor at zero");
        rd(17, 32'hFFFF_0000, "R11 zero credit no pending");
        // R6 with zero credit: no error
        strobe(8'h00, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0);
        rd(16, 32'h0, "R6 full with zero credit");
        // R3 saturation
        @(negedge clk);
        credit_grant = 8'h01;
        repeat (40) @(negedge clk);
        credit_grant = 8'h00;
        rd(8, 32'd31, "R3 saturation");
        // R6 credit error
        strobe(8'h00, 8'h00, 8'h03, 8'h00, 1'b0, 1'b0);
        rd(16, 32'h0000_0001, "R6 credit error ch0 only");
        // R5 halt clears and ignores grants
        wr(0, 32'h0);
        rd(8, 32'd0, "R5 halted credit");
        strobe(8'h01, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
        rd(8, 32'd0, "R5 grant ignored");
        // R5 drain mode counts; R11 no pending outside run mode
        wr(5, 32'h4000_0008);
        strobe(8'h20, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
        rd(13, 32'd1, "R5 drain mode counts");
        rd(17, 32'hFFFF_0000, "R11 drain not pending");
        // R7 activate error; R11 empty bit
        @(negedge clk);
        req_buf_busy = 8'h04;
        strobe(8'h00, 8'h00, 8'h00, 8'h0C, 1'b0, 1'b0);
        rd(16, 32'h0000_0801, "R7 activate error ch2");
        rd(17, 32'hFBFF_0000, "R11 ch2 buffer busy");
        @(negedge clk);
        req_buf_busy = 8'h00;
        // R8
        strobe(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
        rd(16, 32'hC000_0801, "R8 address and count errors");
        // R9 write one clears, zero keeps
        wr(16, 32'h0000_0001);
        rd(16, 32'hC000_0800, "R9 clear bit 0");
        wr(16, 32'h0);
        rd(16, 32'hC000_0800, "R9 zero write keeps");
        // R10 set wins over clear in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(16); reg_wdata = 32'h8000_0000; addr_err = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; addr_err = 1'b0;
        rd(16, 32'hC000_0800, "R10 set beats clear");
        wr(16, 32'hFFFF_FFFF);
        rd(16, 32'h0, "R9 clear all");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule